// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Cascade Link

The controller gathers eight level-sensitive interrupt request lines, holds each request until it is serviced, and raises one interrupt line to the processor when a pending request outranks everything already in service. Line 0 is the most urgent and line 7 the least. When the processor pulses the acknowledge input, the controller picks the most urgent eligible line and marks it in service. In the following cycle it drives an 8-bit vector, made of a 5-bit base followed by the 3-bit line number. An end-of-interrupt pulse retires the most urgent in-service line, and the interrupt output then reflects what is still pending.

Two copies of the same module form a fifteen-line system. The slave's interrupt output feeds line 2 of the master, and the master's cascade enable is set. When the master grants line 2 at acknowledge, it keeps its own vector off the bus and pulses its slave-acknowledge output in the same cycle. That output serves as the slave's acknowledge, so the slave places its own vector on the bus in the next cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request input sampled high on a clock edge sets that line's pending bit. The bit stays set after the request falls and is cleared only when that line is granted by an acknowledge.
- R2: `irq` is high exactly when some pending line has a lower number than every in-service line. When no line is in service, any pending line qualifies. Line 0 has the highest priority.
- R3: When several eligible lines are pending, an acknowledge grants the lowest-numbered one.
- R4: When `ack` is high on an edge while `irq` is high, the granted line's pending bit clears and its in-service bit sets. Unless R7 applies, `vec_oe` is high for the one following cycle, and `vec` = {`vec_base`, 3-bit line number}.
- R5: While a line is in service, a request on a lower-numbered line raises `irq` and can be granted. A new request on the same line or a higher-numbered line leaves `irq` low.
- R6: An `eoi` pulse clears the in-service bit of the lowest-numbered in-service line. From the next cycle, `irq` follows R2 with the remaining in-service set.
- R7: With `casc_en` high, if line 2 is the granted line, `slave_ack` is high during the acknowledge cycle and `vec_oe` stays low in the following cycle. A slave whose `ack` is driven by `slave_ack` drives its own vector in that following cycle.
- R8: An `ack` while `irq` is low changes no state and leaves `vec_oe` low.
- R9: After reset, `irq`, `vec_oe` and `slave_ack` are low, and no line is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 8 | Level-high request lines, line 0 most urgent |
| vec_base | input | 5 | Upper five bits of every vector |
| casc_en | input | 1 | Master mode: line 2 links to a slave controller |
| ack | input | 1 | Interrupt acknowledge pulse (from the processor, or from the master's slave_ack) |
| eoi | input | 1 | End-of-interrupt pulse |
| irq | output | 1 | Interrupt request to the processor (or to the master's line 2) |
| vec_oe | output | 1 | Vector output enable, one cycle after a grant |
| vec | output | 8 | Vector: base and line number |
| slave_ack | output | 1 | Acknowledge forwarded to the slave when line 2 is granted in cascade |

## Verification
On every cycle, the assertions check four things. Pending bits never vanish without an acknowledge. The in-service set only grows on an acknowledge, and each unopposed end-of-interrupt removes exactly one bit from it. A vector enable always follows an acknowledge and never follows a cascade hand-off. Only the bench's scenarios can show the following:
- which line is chosen among competing requests;
- the vector value;
- that an equal or lower request waits behind an in-service line while a higher one preempts it;
- that a slave line travels through the master's line 2 and lands on the bus with the slave's base.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLINES    = 8,
  parameter int CASC_LINE = 2,
  parameter int VEC_W     = 8,
  localparam int IW       = $clog2(NLINES),
  localparam int BASE_W   = VEC_W - IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req,
  input  logic [BASE_W-1:0] vec_base,
  input  logic              casc_en,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq,
  output logic              vec_oe,
  output logic [VEC_W-1:0]  vec,
  output logic              slave_ack
);

  logic [NLINES-1:0] pend, isr, allow, elig, grant, eoi_clr;
  logic [IW-1:0]     sel_idx;
  logic              take;

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      if (isr[i]) blocked = 1'b1;
      allow[i] = !blocked;
    end
  end

  assign elig    = pend & allow;
  assign grant   = elig & (~elig + 1'b1);
  assign eoi_clr = eoi ? (isr & (~isr + 1'b1)) : '0;
  assign irq     = |elig;
  assign take    = ack && irq;
  assign slave_ack = take && casc_en && grant[CASC_LINE];

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NLINES; i++)
      if (grant[i]) sel_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      isr    <= '0;
      vec_oe <= 1'b0;
      vec    <= '0;
    end else begin
      pend   <= (pend | req) & ~(take ? grant : '0);
      isr    <= (isr & ~eoi_clr) | (take ? grant : '0);
      vec_oe <= take && !slave_ack;
      if (take) vec <= {vec_base, sel_idx};
    end
  end

  p_pend_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((pend & $past(pend)) == $past(pend)));

  p_isr_grows_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ($countones(isr) <= $countones($past(isr))));

  p_oe_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> $past(ack));

  p_eoi_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && (|isr)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  p_master_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ack |=> !vec_oe);

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] mreq = '0, sreq = '0;
  logic       casc_en = 1'b0, ack = 1'b0, m_eoi = 1'b0, s_eoi = 1'b0;
  logic       m_irq, m_oe, m_sack, s_irq, s_oe, s_sack;
  logic [7:0] m_vec, s_vec, m_req_in;
  localparam logic [4:0] MB = 5'h04, SB = 5'h09;

  assign m_req_in = {mreq[7:3], casc_en ? s_irq : mreq[2], mreq[1:0]};

  prio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .req(m_req_in), .vec_base(MB),
    .casc_en(casc_en), .ack(ack), .eoi(m_eoi), .irq(m_irq), .vec_oe(m_oe),
    .vec(m_vec), .slave_ack(m_sack));

  prio_irq_ctrl slv (.clk(clk), .rst_n(rst_n), .req(sreq), .vec_base(SB),
    .casc_en(1'b0), .ack(m_sack), .eoi(s_eoi), .irq(s_irq), .vec_oe(s_oe),
    .vec(s_vec), .slave_ack(s_sack));

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_req(logic [7:0] m, logic [7:0] s);
    mreq = m; sreq = s; tick(); mreq = '0; sreq = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_eoi(logic m, logic s);
    m_eoi = m; s_eoi = s; tick(); m_eoi = 1'b0; s_eoi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 irq", m_irq, 0);
    chk("R9 vec_oe", m_oe, 0);
    chk("R9 slave_ack", m_sack, 0);
    rst_n = 1'b1;
    tick();
    chk("R9 idle irq", m_irq, 0);

    do_ack();
    chk("R8 no oe", m_oe, 0);
    chk("R8 irq", m_irq, 0);

    for (int i = 0; i < 8; i++) begin
      pulse_req(8'(1 << i), '0);
      tick();
      chk("R1 latched irq", m_irq, 1);
      do_ack();
      chk("R4 oe", m_oe, 1);
      chk("R4 vec", m_vec, {MB, 3'(i)});
      chk("R4 pend cleared irq", m_irq, 0);
      tick();
      chk("R4 oe one cycle", m_oe, 0);
      do_eoi(1, 0);
      chk("R6 idle", m_irq, 0);
    end

    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++) begin
        pulse_req(8'((1 << i) | (1 << j)), '0);
        chk("R2 irq", m_irq, 1);
        do_ack();
        chk("R3 vec", m_vec, {MB, 3'(i)});
        chk("R5 lower waits", m_irq, 0);
        do_eoi(1, 0);
        chk("R6 reeval", m_irq, 1);
        do_ack();
        chk("R3 second vec", m_vec, {MB, 3'(j)});
        do_eoi(1, 0);
        chk("R6 empty", m_irq, 0);
      end

    pulse_req(8'h20, '0);
    do_ack();
    chk("R5 base", m_vec, {MB, 3'd5});
    pulse_req(8'h20, '0);
    chk("R5 equal waits", m_irq, 0);
    pulse_req(8'h80, '0);
    chk("R5 lower waits nested", m_irq, 0);
    pulse_req(8'h08, '0);
    chk("R5 higher preempts", m_irq, 1);
    do_ack();
    chk("R5 nested vec", m_vec, {MB, 3'd3});
    chk("R5 under two", m_irq, 0);
    do_eoi(1, 0);
    chk("R6 back to 5", m_irq, 0);
    do_eoi(1, 0);
    chk("R6 pending 5 after", m_irq, 1);
    do_ack();
    chk("R6 vec 5", m_vec, {MB, 3'd5});
    do_eoi(1, 0);
    chk("R6 pending 7", m_irq, 1);
    do_ack();
    chk("R6 vec 7", m_vec, {MB, 3'd7});
    do_eoi(1, 0);
    chk("R6 drained", m_irq, 0);

    casc_en = 1'b1;
    tick();
    for (int s = 0; s < 8; s++) begin
      pulse_req('0, 8'(1 << s));
      tick();
      chk("R7 master irq", m_irq, 1);
      ack = 1'b1;
      #1;
      chk("R7 slave_ack", m_sack, 1);
      @(negedge clk);
      ack = 1'b0;
      chk("R7 master oe", m_oe, 0);
      chk("R7 slave oe", s_oe, 1);
      chk("R7 slave vec", s_vec, {SB, 3'(s)});
      do_eoi(1, 1);
      chk("R7 done", m_irq, 0);
    end

    pulse_req(8'h02, 8'h20);
    tick();
    do_ack();
    chk("R7 master line1 first", m_vec, {MB, 3'd1});
    chk("R7 master oe", m_oe, 1);
    chk("R5 slave waits", m_irq, 0);
    do_eoi(1, 0);
    chk("R7 slave pending", m_irq, 1);
    do_ack();
    chk("R7 slave oe 2", s_oe, 1);
    chk("R7 slave vec 5", s_vec, {SB, 3'd5});
    do_eoi(1, 1);

    pulse_req(8'h08, 8'h01);
    tick();
    do_ack();
    chk("R3 slave beats line3", s_vec, {SB, 3'd0});
    chk("R3 master quiet", m_oe, 0);
    do_eoi(1, 1);
    do_ack();
    chk("R3 line3 next", m_vec, {MB, 3'd3});
    do_eoi(1, 0);
    chk("R6 cascade drained", m_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule